// File: doc/BRIEF.md
# DS3 Receive Alarm Interrupt Collector

This block gathers eight single-cycle event pulses from the receive side of a DS3 framer and turns them into one interrupt request for the host. The eight sources are CP-bit error, loss of signal, AIS, idle, FERF, AIC change, out-of-frame and P-bit error. Each pulse sets a sticky flag. A matching mask bit decides whether that flag raises the interrupt line. The host reads the pending flags, and the read itself clears them.

The block also keeps a saturating 16-bit count of CP-bit errors. The host reads the count as two bytes, upper byte first. Reading the upper byte freezes the lower byte, so the two halves belong to the same value. Reading the lower byte restarts the count.

All access uses a byte-wide register port with an address, a read strobe, a write strobe and write data. Read data is combinational from the current state. Read side effects take place on the clock edge at which the read strobe is high.

Top module: `ds3_rx_alarm_irq`

## Requirements
- R1: After reset the mask register, all flags and the error count are zero, `irq_o` is low, and `bus_rdata` is 0x00 whenever `bus_rd` is low.
- R2: The mask register at address 0x12 is read/write and takes `bus_wdata` on a write strobe. A 1 in a bit enables that source.
- R3: An event pulse sets its flag on the next clock edge. The bit positions, bit 7 down to bit 0, are: CP-bit error, LOS, AIS, idle, FERF, AIC, OOF, P-bit error. The flag is set even when its mask bit is 0.
- R4: `irq_o` is high exactly when some flag is set while its mask bit is 1. The line rises the cycle after the edge that latches such an event, and it is low whenever the mask is zero.
- R5: A read of address 0x13 returns the flags, using the same bit positions as the mask. That read clears every flag on its clock edge.
- R6: An event that arrives in the same cycle as a clearing read of 0x13 stays set after the read.
- R7: Each cycle with bit 7 of `evt_i` high adds one to the error count. A read of 0x72 returns the upper count byte and freezes the lower byte. A later read of 0x73 returns that frozen byte, even if more errors have arrived in between.
- R8: The error count holds at 0xFFFF and does not wrap.
- R9: A read of 0x73 restarts the count at zero. If a CP-bit error arrives in the same cycle, the count restarts at one.
- R10: Reads of any address other than 0x12, 0x13, 0x72 and 0x73 return 0x00. Writes to 0x13, 0x72, 0x73 or to an unmapped address change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | Event pulses; bit 7 CP-bit error, 6 LOS, 5 AIS, 4 idle, 3 FERF, 2 AIC, 1 OOF, 0 P-bit error |
| bus_addr | input | 8 | Register byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The flag and mask logic is driven from a table of event and mask pairs. The table covers single sources, sources without their mask bit, disjoint event and mask patterns, and all sources at once. Together these separate a wrong bit position, a missing mask, an OR that ignores the mask and a clear that misses bits. Directed sequences then check the corner cases around the reads:
- an event that lands on a clearing read;
- error pulses that arrive between the two count reads, which shows whether the lower byte is really frozen;
- a long burst that runs past 0xFFFF;
- an error that coincides with the restarting read;
- writes to read-only and unmapped addresses.

// File: rtl/rxalm_pkg.sv
package rxalm_pkg;
  localparam int BUS_W = 8;
  localparam int N_SRC = 8;

  localparam logic [BUS_W-1:0] A_MASK   = 8'h12;
  localparam logic [BUS_W-1:0] A_FLAGS  = 8'h13;
  localparam logic [BUS_W-1:0] A_CNT_HI = 8'h72;
  localparam logic [BUS_W-1:0] A_CNT_LO = 8'h73;

  // source positions shared by mask and flag registers
  localparam int S_CPBIT = 7;
  localparam int S_LOS   = 6;
  localparam int S_AIS   = 5;
  localparam int S_IDLE  = 4;
  localparam int S_FERF  = 3;
  localparam int S_AIC   = 2;
  localparam int S_OOF   = 1;
  localparam int S_PBIT  = 0;

  typedef enum logic [2:0] {
    RS_NONE, RS_MASK, RS_FLAGS, RS_CNT_HI, RS_CNT_LO
  } rsel_e;

  function automatic logic pending_any(input logic [N_SRC-1:0] flags,
                                       input logic [N_SRC-1:0] mask);
    return |(flags & mask);
  endfunction

  function automatic rsel_e decode(input logic [BUS_W-1:0] addr);
    case (addr)
      A_MASK:   return RS_MASK;
      A_FLAGS:  return RS_FLAGS;
      A_CNT_HI: return RS_CNT_HI;
      A_CNT_LO: return RS_CNT_LO;
      default:  return RS_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rxalm_regbus.sv
module rxalm_regbus
  import rxalm_pkg::*;
#(
  parameter int AW = BUS_W,
  parameter int DW = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] mask_q_i,
  input  logic [DW-1:0] flags_q_i,
  input  logic [DW-1:0] cnt_hi_i,
  input  logic [DW-1:0] cnt_lo_i,
  output logic          mask_wr_o,
  output logic          flags_clr_o,
  output logic          cnt_hi_rd_o,
  output logic          cnt_lo_rd_o,
  output logic [DW-1:0] rdata_o
);
  rsel_e sel;

  assign sel         = decode(addr_i);
  assign mask_wr_o   = wr_i && (sel == RS_MASK);
  assign flags_clr_o = rd_i && (sel == RS_FLAGS);
  assign cnt_hi_rd_o = rd_i && (sel == RS_CNT_HI);
  assign cnt_lo_rd_o = rd_i && (sel == RS_CNT_LO);

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (sel)
        RS_MASK:   rdata_o = mask_q_i;
        RS_FLAGS:  rdata_o = flags_q_i;
        RS_CNT_HI: rdata_o = cnt_hi_i;
        RS_CNT_LO: rdata_o = cnt_lo_i;
        default:   rdata_o = '0;
      endcase
    end
  end

  // R10: unmapped reads return zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i != A_MASK && addr_i != A_FLAGS &&
     addr_i != A_CNT_HI && addr_i != A_CNT_LO) |-> (rdata_o == '0));
  // R1: no strobe, no data
  a_r1_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |-> (rdata_o == '0));
endmodule

// File: rtl/rxalm_flags.sv
module rxalm_flags
  import rxalm_pkg::*;
#(
  parameter int N = N_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         mask_wr_i,
  input  logic [N-1:0] mask_wdata_i,
  input  logic         clr_i,
  output logic [N-1:0] mask_q_o,
  output logic [N-1:0] flags_q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)         mask_q_o <= '0;
    else if (mask_wr_i) mask_q_o <= mask_wdata_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)        flags_q_o[g] <= 1'b0;
      else if (evt_i[g]) flags_q_o[g] <= 1'b1;   // R6: event wins over clear
      else if (clr_i)    flags_q_o[g] <= 1'b0;
    end

    // R3: a pulse always leaves its flag set
    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[g] |=> flags_q_o[g]);
    // R5: a clearing read without a new event drops the flag
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !evt_i[g]) |=> !flags_q_o[g]);
    // R3: flags only rise because of an event
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags_q_o[g] && !evt_i[g]) |=> !flags_q_o[g]);
  end
endmodule

// File: rtl/rxalm_errcnt.sv
module rxalm_errcnt
  import rxalm_pkg::*;
#(
  parameter int DW = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err_i,
  input  logic          hi_rd_i,
  input  logic          lo_rd_i,
  output logic [DW-1:0] hi_o,
  output logic [DW-1:0] lo_o
);
  localparam int CW = 2 * DW;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] snap_q;

  function automatic logic [CW-1:0] sat_step(input logic [CW-1:0] c,
                                             input logic e);
    return (e && c != CMAX) ? c + ONE : c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (lo_rd_i) cnt_q <= err_i ? ONE : '0;
    else              cnt_q <= sat_step(cnt_q, err_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       snap_q <= '0;
    else if (hi_rd_i) snap_q <= cnt_q[DW-1:0];
  end

  assign hi_o = cnt_q[CW-1:DW];
  assign lo_o = snap_q;

  // R7: between restarts the count never goes down
  a_r7_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_rd_i |=> (cnt_q >= $past(cnt_q)));
  // R8: saturation holds
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CMAX && !lo_rd_i) |=> (cnt_q == CMAX));
  // R9: restart leaves at most one
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd_i |=> (cnt_q <= ONE));
  // R7: frozen byte moves only on an upper-byte read
  a_r7_snap_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_rd_i |=> $stable(snap_q));
endmodule

// File: rtl/ds3_rx_alarm_irq.sv
module ds3_rx_alarm_irq
  import rxalm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [BUS_W-1:0] bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq_o
);
  logic             mask_wr, flags_clr, cnt_hi_rd, cnt_lo_rd;
  logic [N_SRC-1:0] mask_q, flags_q;
  logic [BUS_W-1:0] cnt_hi, cnt_lo;

  rxalm_regbus #(.AW(BUS_W), .DW(BUS_W)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .addr_i(bus_addr), .rd_i(bus_rd), .wr_i(bus_wr),
    .mask_q_i(mask_q), .flags_q_i(flags_q),
    .cnt_hi_i(cnt_hi), .cnt_lo_i(cnt_lo),
    .mask_wr_o(mask_wr), .flags_clr_o(flags_clr),
    .cnt_hi_rd_o(cnt_hi_rd), .cnt_lo_rd_o(cnt_lo_rd),
    .rdata_o(bus_rdata)
  );

  rxalm_flags #(.N(N_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .mask_wr_i(mask_wr), .mask_wdata_i(bus_wdata),
    .clr_i(flags_clr), .mask_q_o(mask_q), .flags_q_o(flags_q)
  );

  rxalm_errcnt #(.DW(BUS_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .err_i(evt_i[S_CPBIT]),
    .hi_rd_i(cnt_hi_rd), .lo_rd_i(cnt_lo_rd),
    .hi_o(cnt_hi), .lo_o(cnt_lo)
  );

  assign irq_o = pending_any(flags_q, mask_q);

  // R4: with every source masked the line stays low
  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);
  // R4: an enabled event raises the line one edge later
  a_r4_enabled_raises: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & mask_q) != '0 && !mask_wr) |=> irq_o);
endmodule

// File: tb/ds3_rx_alarm_irq_test.sv
module ds3_rx_alarm_irq_test;
  localparam int CYC = 10;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_i = '0, bus_addr = '0, bus_wdata = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq_o;
  int         errors = 0, checks = 0;
  logic [7:0] rd;

  always #(CYC/2) clk = ~clk;

  ds3_rx_alarm_irq uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // {events, mask}
  localparam int NV = 9;
  localparam logic [15:0] VEC [NV] = '{
    16'h80_80, 16'h01_01, 16'h40_00, 16'hA5_5A, 16'hFF_FF,
    16'h3C_04, 16'h02_FD, 16'h18_10, 16'h00_FF
  };

  task automatic chk(input bit ok, input string tag,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [7:0] ev,
                          output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; evt_i = ev;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; evt_i = '0;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] e, input int n);
    @(negedge clk);
    evt_i = e;
    repeat (n) @(negedge clk);
    evt_i = '0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CYC * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    #1 chk(irq_o == 1'b0, "R1 irq", irq_o, 0);
    chk(bus_rdata == 8'h00, "R1 idle rdata", bus_rdata, 0);
    bus_read(8'h12, 8'h00, rd); chk(rd == 8'h00, "R1 mask", rd, 0);
    bus_read(8'h13, 8'h00, rd); chk(rd == 8'h00, "R1 flags", rd, 0);
    bus_read(8'h72, 8'h00, rd); chk(rd == 8'h00, "R1 cnt hi", rd, 0);
    bus_read(8'h73, 8'h00, rd); chk(rd == 8'h00, "R1 cnt lo", rd, 0);

    // table: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      logic [7:0] ev, mk;
      logic       exp_irq;
      ev = VEC[i][15:8]; mk = VEC[i][7:0];
      exp_irq = (ev & mk) != 8'h00;
      bus_write(8'h12, mk);
      bus_read(8'h12, 8'h00, rd); chk(rd == mk, "R2 mask readback", rd, mk);
      pulse(ev, 1);
      #1 chk(irq_o == exp_irq, "R4 irq after event", irq_o, exp_irq);
      bus_read(8'h13, 8'h00, rd); chk(rd == ev, "R3 R5 flags", rd, ev);
      #1 chk(irq_o == 1'b0, "R5 irq after clear", irq_o, 0);
      bus_read(8'h13, 8'h00, rd); chk(rd == 8'h00, "R5 cleared", rd, 0);
    end

    // R4: masked to zero after the event drops the line
    bus_write(8'h12, 8'h20);
    pulse(8'h20, 1);
    #1 chk(irq_o == 1'b1, "R4 enabled high", irq_o, 1);
    bus_write(8'h12, 8'h00);
    #1 chk(irq_o == 1'b0, "R4 mask off low", irq_o, 0);
    bus_write(8'h12, 8'h20);
    #1 chk(irq_o == 1'b1, "R4 mask on high", irq_o, 1);
    bus_read(8'h13, 8'h00, rd);

    // R6: event on the clearing read survives
    pulse(8'h01, 1);
    bus_read(8'h13, 8'h08, rd); chk(rd == 8'h01, "R6 old flags", rd, 8'h01);
    bus_read(8'h13, 8'h00, rd); chk(rd == 8'h08, "R6 kept", rd, 8'h08);

    // restart the count
    bus_read(8'h72, 8'h00, rd);
    bus_read(8'h73, 8'h00, rd);
    bus_read(8'h72, 8'h00, rd); chk(rd == 8'h00, "R9 restarted hi", rd, 0);
    bus_read(8'h73, 8'h00, rd); chk(rd == 8'h00, "R9 restarted lo", rd, 0);

    // R7: 259 errors, frozen low byte
    pulse(8'h80, 259);
    bus_read(8'h72, 8'h00, rd); chk(rd == 8'h01, "R7 hi", rd, 8'h01);
    pulse(8'h80, 2);
    bus_read(8'h73, 8'h00, rd); chk(rd == 8'h03, "R7 frozen lo", rd, 8'h03);
    bus_read(8'h72, 8'h00, rd); chk(rd == 8'h00, "R9 hi after lo", rd, 0);
    bus_read(8'h73, 8'h00, rd); chk(rd == 8'h00, "R9 lo after lo", rd, 0);

    // R9: error coinciding with the restarting read
    bus_read(8'h73, 8'h80, rd);
    bus_read(8'h72, 8'h00, rd); chk(rd == 8'h00, "R9 coincide hi", rd, 0);
    bus_read(8'h73, 8'h00, rd); chk(rd == 8'h01, "R9 coincide lo", rd, 1);

    // R8: saturation
    pulse(8'h80, 65600);
    bus_read(8'h72, 8'h00, rd); chk(rd == 8'hFF, "R8 sat hi", rd, 8'hFF);
    bus_read(8'h73, 8'h00, rd); chk(rd == 8'hFF, "R8 sat lo", rd, 8'hFF);

    // R10: read-only and unmapped addresses
    bus_read(8'h13, 8'h00, rd);
    bus_write(8'h12, 8'h3C);
    bus_write(8'h13, 8'hFF);
    bus_write(8'h72, 8'hFF);
    bus_write(8'h73, 8'hFF);
    bus_write(8'h55, 8'hFF);
    bus_read(8'h13, 8'h00, rd); chk(rd == 8'h00, "R10 flags not written", rd, 0);
    bus_read(8'h12, 8'h00, rd); chk(rd == 8'h3C, "R10 mask unchanged", rd, 8'h3C);
    bus_read(8'h72, 8'h00, rd); chk(rd == 8'h00, "R10 cnt hi", rd, 0);
    bus_read(8'h73, 8'h00, rd); chk(rd == 8'h00, "R10 cnt lo", rd, 0);
    pulse(8'h04, 1);
    bus_read(8'h55, 8'h00, rd); chk(rd == 8'h00, "R10 unmapped read", rd, 0);
    bus_read(8'h11, 8'h00, rd); chk(rd == 8'h00, "R10 unmapped read 2", rd, 0);
    #1 chk(irq_o == 1'b1, "R4 unmapped read keeps irq", irq_o, 1);

    summary();
  end
endmodule